// File: doc/BRIEF.md
# Two-Level IO Address Translator

The block turns bus addresses issued by IO devices into physical addresses. Software sets up a first-level table of 64 on-chip descriptors. Each descriptor covers a 32 MB span of the bus space and takes one of two forms. The first form maps the whole span directly onto a 32 MB-aligned physical region. The second form points at a second-level table in memory, which holds one 4-byte entry for each 4 KB page. The block fetches these entries over a single-outstanding read port.

A configuration port gives software access to the following:
- write and read access to the descriptors;
- a window register that limits how much bus space is translated;
- a command register whose enable bit turns translation on;
- a write-only invalidate register.

Translated pages are kept in an 8-entry fully associative cache with round-robin replacement. A write to the invalidate register drops every cached page that falls in the 16 KB region it names.

Each translation request receives one response. The response carries a physical address and cached/priority attributes, or a single fault flag. The low 12 bits of the address always pass through unchanged.

Top module: `iox_translator`

## Requirements
- R1: After reset, translation is disabled, the window code is 00, and every descriptor reads as zero. No response or memory request is pending, and the request port is ready.
- R2: While command bit 8 is clear, each request returns the bus address unchanged as the physical address. It returns no fault, cached=0 and prio=0, issues no memory read, and the response appears two clocks after acceptance.
- R3: Window register bits [1:0] select the translated range: 00 means bus addresses below 2^28, 01 below 2^31, and 11 below 2^37. Code 10 is reserved. A bus address outside the range, or the reserved code, gives a fault without a memory read. This check is made before the cache is consulted.
- R4: The descriptor used is the one indexed by bus address bits [30:25]. The descriptor at index i sits at configuration offset 0x2B00+4*i. A descriptor with bit 30 clear gives a fault without a memory read, whatever its bit 31.
- R5: A valid descriptor with bit 31 set maps the bus address directly. The physical address is {descriptor[29:13], bus[24:0]}, cached = descriptor bit 1, and prio = descriptor bit 0. No memory read is issued.
- R6: A valid descriptor with bit 31 clear causes exactly one memory read, at address ({descriptor[29:0], 12'b0} + 4*bus[24:12]). The request is held with a stable address until the memory responds.
- R7: For the fetched second-level word, bit 31 marks it valid, and if clear the result is a fault. Otherwise the physical address is {word[29:0], bus[11:0]}, cached = word bit 30, and prio = 0. The response appears on the clock after the memory response.
- R8: A successful translation while enabled is cached per 4 KB page. A later request to that page completes in two clocks without a memory read, even after its descriptor has been rewritten. Faults are never cached.
- R9: Writing value V to offset 0x2D00 removes every cached page whose bus address shifted right by 14 equals V. Pages in other 16 KB regions stay cached.
- R10: The cache holds 8 pages and refills slots in round-robin order. The ninth new page replaces the first one filled and leaves the second one in place.
- R11: The command register (offset 0x100), the window register (offset 0x14C) and the descriptors read back their last written 32-bit value combinationally. The invalidate offset and all other offsets read zero.
- R12: A fault response carries physical address 0, cached=0 and prio=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 14 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on cfg_addr) |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Translator idle and accepting a request |
| xl_req_addr | input | BA_W | Bus address to translate |
| xl_rsp_valid | output | 1 | One-cycle response strobe |
| xl_rsp_paddr | output | PA_W | Physical address |
| xl_rsp_fault | output | 1 | Translation fault |
| xl_rsp_cached | output | 1 | Cached attribute |
| xl_rsp_prio | output | 1 | Priority attribute |
| mem_req_valid | output | 1 | Second-level fetch request, held until answered |
| mem_req_addr | output | PA_W | Second-level entry byte address |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 32 | Fetched second-level entry |

## Verification
A request accepted on one clock edge produces its response on the second edge after it. This holds for pass-through, faults, direct-mapped spans and cache hits. When a fetch is needed, the response comes one edge after the memory answers. Configuration writes take effect on the edge that samples them, and reads are combinational. The bench drives and samples on falling edges. It counts falling edges from acceptance to the response strobe, requires exactly two when no fetch was made, and counts the fetches that the memory model answered to prove which paths touched memory.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int unsigned PG_SH   = 12;
  localparam int unsigned ENT_W   = 32;
  localparam int unsigned PPN_W   = 30;
  localparam int unsigned PA_W    = PPN_W + PG_SH;
  localparam int unsigned CFG_AW  = 14;
  localparam int unsigned SPAN_SH = 25;

  localparam logic [CFG_AW-1:0] OFS_CMD = 14'h0100;
  localparam logic [CFG_AW-1:0] OFS_WIN = 14'h014C;
  localparam logic [CFG_AW-1:0] OFS_DSC = 14'h2B00;
  localparam logic [CFG_AW-1:0] OFS_INV = 14'h2D00;

  localparam int unsigned CMD_EN_BIT  = 8;
  localparam int unsigned DSC_V_BIT   = 30;
  localparam int unsigned DSC_BIG_BIT = 31;
  localparam int unsigned DSC_C_BIT   = 1;
  localparam int unsigned DSC_P_BIT   = 0;
  localparam int unsigned L2_V_BIT    = 31;
  localparam int unsigned L2_C_BIT    = 30;

  localparam int unsigned WIN_SH_S = 28;
  localparam int unsigned WIN_SH_M = 31;
  localparam int unsigned WIN_SH_L = 37;

  typedef enum logic [1:0] {
    WIN_256M = 2'b00,
    WIN_2G   = 2'b01,
    WIN_RSVD = 2'b10,
    WIN_128G = 2'b11
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } wstate_e;

  typedef struct packed {
    logic             cached;
    logic             prio;
    logic [PPN_W-1:0] ppn;
  } xres_t;
endpackage

// File: rtl/iox_cfg_regs.sv
module iox_cfg_regs
  import iox_pkg::*;
#(
  parameter int unsigned L1_N  = 64,
  parameter int unsigned KEY_W = 26,
  localparam int unsigned L1_IW = $clog2(L1_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] addr,
  input  logic [ENT_W-1:0]  wdata,
  output logic [ENT_W-1:0]  rdata,
  input  logic [L1_IW-1:0]  dsc_idx,
  output logic [ENT_W-1:0]  dsc_ent,
  output logic              xl_en,
  output logic [1:0]        win_code,
  output logic              inv_fire,
  output logic [KEY_W-1:0]  inv_key
);
  logic [ENT_W-1:0]  dsc_q [L1_N];
  logic [ENT_W-1:0]  cmd_q, win_q;
  logic [CFG_AW-1:0] dsc_rel;
  logic              dsc_sel;
  logic [L1_IW-1:0]  dsc_off;
  logic [L1_N-1:0]   dsc_we;
  logic              cmd_we, win_we;

  assign dsc_rel = addr - OFS_DSC;
  assign dsc_sel = (addr >= OFS_DSC) && (dsc_rel < CFG_AW'(L1_N * 4)) && (addr[1:0] == 2'b00);
  assign dsc_off = dsc_rel[L1_IW+1:2];
  assign cmd_we  = wr && (addr == OFS_CMD);
  assign win_we  = wr && (addr == OFS_WIN);

  for (genvar g = 0; g < L1_N; g++) begin : g_dsc_we
    assign dsc_we[g] = wr && dsc_sel && (dsc_off == L1_IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L1_N; i++) dsc_q[i] <= '0;
    end else begin
      for (int i = 0; i < L1_N; i++) if (dsc_we[i]) dsc_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_we) win_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (dsc_sel)               rdata = dsc_q[dsc_off];
    else if (addr == OFS_CMD)  rdata = cmd_q;
    else if (addr == OFS_WIN)  rdata = win_q;
  end

  assign dsc_ent  = dsc_q[dsc_idx];
  assign xl_en    = cmd_q[CMD_EN_BIT];
  assign win_code = win_q[1:0];
  assign inv_fire = wr && (addr == OFS_INV);
  assign inv_key  = wdata[KEY_W-1:0];
endmodule

// File: rtl/iox_tlb.sv
module iox_tlb
  import iox_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 28,
  localparam int unsigned PW    = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned KEY_W = VPN_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output xres_t            hit_res,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  xres_t            fill_res,
  input  logic             inv,
  input  logic [KEY_W-1:0] inv_key
);
  logic [N-1:0]     v_q, v_d;
  logic [VPN_W-1:0] tag_q [N];
  xres_t            res_q [N];
  logic [PW-1:0]    ptr_q, ptr_d;
  logic [N-1:0]     match, drop, slot_fill;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign match[g]     = v_q[g] && (tag_q[g] == lk_vpn);
    assign drop[g]      = inv && (tag_q[g][VPN_W-1:2] == inv_key);
    assign slot_fill[g] = fill && (ptr_q == PW'(g));
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (slot_fill[i])  v_d[i] = 1'b1;
      else if (drop[i])  v_d[i] = 1'b0;
      else               v_d[i] = v_q[i];
    end
    ptr_d = ptr_q;
    if (fill) ptr_d = (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      ptr_q <= '0;
    end else begin
      v_q   <= v_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (slot_fill[i]) begin
          tag_q[i] <= fill_vpn;
          res_q[i] <= fill_res;
        end
      end
    end
  end

  always_comb begin
    hit     = |match;
    hit_res = '0;
    for (int i = 0; i < N; i++) if (match[i]) hit_res = hit_res | res_q[i];
  end
endmodule

// File: rtl/iox_walk.sv
module iox_walk
  import iox_pkg::*;
#(
  parameter int unsigned BA_W = 40,
  parameter int unsigned L1_N = 64,
  localparam int unsigned VPN_W = BA_W - PG_SH,
  localparam int unsigned L1_IW = $clog2(L1_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BA_W-1:0]  req_addr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_cached,
  output logic             rsp_prio,
  input  logic             xl_en,
  input  logic [1:0]       win_code,
  output logic [L1_IW-1:0] dsc_idx,
  input  logic [ENT_W-1:0] dsc_ent,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             tlb_hit,
  input  xres_t            tlb_res,
  output logic             fill,
  output xres_t            fill_res,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data
);
  wstate_e         st_q, st_d;
  logic [BA_W-1:0] va_q, va_d;
  logic            rv_q, rv_d, f_q, f_d, c_q, c_d, p_q, p_d;
  logic [PA_W-1:0] pa_q, pa_d, ma_q, ma_d;
  logic            win_ok;
  logic [PG_SH-1:0] pg_off;
  logic [SPAN_SH-PG_SH-1:0] l2_idx;

  assign pg_off  = va_q[PG_SH-1:0];
  assign l2_idx  = va_q[SPAN_SH-1:PG_SH];
  assign dsc_idx = va_q[SPAN_SH+L1_IW-1:SPAN_SH];
  assign lk_vpn  = va_q[BA_W-1:PG_SH];

  always_comb begin
    unique case (win_e'(win_code))
      WIN_256M: win_ok = (va_q >> WIN_SH_S) == '0;
      WIN_2G:   win_ok = (va_q >> WIN_SH_M) == '0;
      WIN_128G: win_ok = (va_q >> WIN_SH_L) == '0;
      default:  win_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    va_d     = va_q;
    rv_d     = 1'b0;
    pa_d     = pa_q;
    f_d      = f_q;
    c_d      = c_q;
    p_d      = p_q;
    ma_d     = ma_q;
    fill     = 1'b0;
    fill_res = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d = req_addr;
          st_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        st_d = ST_IDLE;
        rv_d = 1'b1;
        pa_d = '0;
        f_d  = 1'b0;
        c_d  = 1'b0;
        p_d  = 1'b0;
        if (!xl_en) begin
          pa_d = PA_W'(va_q);
        end else if (!win_ok) begin
          f_d = 1'b1;
        end else if (tlb_hit) begin
          pa_d = {tlb_res.ppn, pg_off};
          c_d  = tlb_res.cached;
          p_d  = tlb_res.prio;
        end else if (!dsc_ent[DSC_V_BIT]) begin
          f_d = 1'b1;
        end else if (dsc_ent[DSC_BIG_BIT]) begin
          fill_res.ppn    = {dsc_ent[PPN_W-1:SPAN_SH-PG_SH], l2_idx};
          fill_res.cached = dsc_ent[DSC_C_BIT];
          fill_res.prio   = dsc_ent[DSC_P_BIT];
          fill = 1'b1;
          pa_d = {fill_res.ppn, pg_off};
          c_d  = fill_res.cached;
          p_d  = fill_res.prio;
        end else begin
          rv_d = 1'b0;
          st_d = ST_WAIT;
          ma_d = {dsc_ent[PPN_W-1:0], {PG_SH{1'b0}}} + PA_W'({l2_idx, 2'b00});
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          st_d = ST_IDLE;
          rv_d = 1'b1;
          pa_d = '0;
          f_d  = 1'b0;
          c_d  = 1'b0;
          p_d  = 1'b0;
          if (mem_rsp_data[L2_V_BIT]) begin
            fill_res.ppn    = mem_rsp_data[PPN_W-1:0];
            fill_res.cached = mem_rsp_data[L2_C_BIT];
            fill = 1'b1;
            pa_d = {fill_res.ppn, pg_off};
            c_d  = fill_res.cached;
          end else begin
            f_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      va_q <= '0;
      rv_q <= 1'b0;
      pa_q <= '0;
      f_q  <= 1'b0;
      c_q  <= 1'b0;
      p_q  <= 1'b0;
      ma_q <= '0;
    end else begin
      st_q <= st_d;
      va_q <= va_d;
      rv_q <= rv_d;
      pa_q <= pa_d;
      f_q  <= f_d;
      c_q  <= c_d;
      p_q  <= p_d;
      ma_q <= ma_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_WAIT);
  assign mem_req_addr  = ma_q;
  assign rsp_valid     = rv_q;
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = f_q;
  assign rsp_cached    = c_q;
  assign rsp_prio      = p_q;
endmodule

// File: rtl/iox_translator.sv
module iox_translator
  import iox_pkg::*;
#(
  parameter int unsigned BA_W  = 40,
  parameter int unsigned L1_N  = 64,
  parameter int unsigned TLB_N = 8,
  localparam int unsigned VPN_W = BA_W - PG_SH,
  localparam int unsigned L1_IW = $clog2(L1_N),
  localparam int unsigned KEY_W = VPN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              xl_req_valid,
  output logic              xl_req_ready,
  input  logic [BA_W-1:0]   xl_req_addr,
  output logic              xl_rsp_valid,
  output logic [PA_W-1:0]   xl_rsp_paddr,
  output logic              xl_rsp_fault,
  output logic              xl_rsp_cached,
  output logic              xl_rsp_prio,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  logic rst_meta, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic [L1_IW-1:0] dsc_idx;
  logic [ENT_W-1:0] dsc_ent;
  logic             xl_en, inv_fire, tlb_hit, fill;
  logic [1:0]       win_code;
  logic [KEY_W-1:0] inv_key;
  logic [VPN_W-1:0] lk_vpn;
  xres_t            tlb_res, fill_res;

  iox_cfg_regs #(.L1_N(L1_N), .KEY_W(KEY_W)) u_cfg (
    .clk(clk), .rst_n(rst_ns), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .dsc_idx(dsc_idx), .dsc_ent(dsc_ent), .xl_en(xl_en),
    .win_code(win_code), .inv_fire(inv_fire), .inv_key(inv_key)
  );

  iox_tlb #(.N(TLB_N), .VPN_W(VPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_ns), .lk_vpn(lk_vpn), .hit(tlb_hit), .hit_res(tlb_res),
    .fill(fill), .fill_vpn(lk_vpn), .fill_res(fill_res), .inv(inv_fire), .inv_key(inv_key)
  );

  iox_walk #(.BA_W(BA_W), .L1_N(L1_N)) u_walk (
    .clk(clk), .rst_n(rst_ns), .req_valid(xl_req_valid), .req_ready(xl_req_ready),
    .req_addr(xl_req_addr), .rsp_valid(xl_rsp_valid), .rsp_paddr(xl_rsp_paddr),
    .rsp_fault(xl_rsp_fault), .rsp_cached(xl_rsp_cached), .rsp_prio(xl_rsp_prio),
    .xl_en(xl_en), .win_code(win_code), .dsc_idx(dsc_idx), .dsc_ent(dsc_ent),
    .lk_vpn(lk_vpn), .tlb_hit(tlb_hit), .tlb_res(tlb_res), .fill(fill),
    .fill_res(fill_res), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/iox_translator_chk.sv
module iox_translator_chk
  import iox_pkg::*;
(
  input logic            clk,
  input logic            rst_ns,
  input logic            xl_req_ready,
  input logic            xl_rsp_valid,
  input logic [PA_W-1:0] xl_rsp_paddr,
  input logic            xl_rsp_fault,
  input logic            xl_rsp_cached,
  input logic            xl_rsp_prio,
  input logic            mem_req_valid,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid
);
  // R2: every response is a single-cycle strobe
  p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    xl_rsp_valid |=> !xl_rsp_valid);

  // R12: a fault carries no address and no attributes
  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    (xl_rsp_valid && xl_rsp_fault) |-> (xl_rsp_paddr == '0 && !xl_rsp_cached && !xl_rsp_prio));

  // R6: an unanswered fetch stays up with the same address
  p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6: no new request is taken while a fetch is outstanding
  p_fetch_busy_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid |-> !xl_req_ready);

  // R6: fetch addresses are word aligned
  p_fetch_align_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R7: the response follows the memory answer by one clock
  p_fetch_done_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req_valid && mem_rsp_valid) |=> (xl_rsp_valid && !mem_req_valid));
endmodule

bind iox_translator iox_translator_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .xl_req_ready(xl_req_ready), .xl_rsp_valid(xl_rsp_valid),
  .xl_rsp_paddr(xl_rsp_paddr), .xl_rsp_fault(xl_rsp_fault), .xl_rsp_cached(xl_rsp_cached),
  .xl_rsp_prio(xl_rsp_prio), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/iox_translator_tb.sv
module iox_translator_tb;
  localparam int BA_W = 40;
  localparam int PA_W = 42;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_wr;
  logic [13:0]     cfg_addr;
  logic [31:0]     cfg_wdata, cfg_rdata;
  logic            xl_req_valid, xl_req_ready;
  logic [BA_W-1:0] xl_req_addr;
  logic            xl_rsp_valid, xl_rsp_fault, xl_rsp_cached, xl_rsp_prio;
  logic [PA_W-1:0] xl_rsp_paddr, mem_req_addr;
  logic            mem_req_valid, mem_rsp_valid;
  logic [31:0]     mem_rsp_data;

  always #2.5 clk = ~clk;

  iox_translator u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
    .xl_req_addr(xl_req_addr), .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(xl_rsp_paddr),
    .xl_rsp_fault(xl_rsp_fault), .xl_rsp_cached(xl_rsp_cached), .xl_rsp_prio(xl_rsp_prio),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0]     mem_img [logic [41:0]];
  int              fetch_cnt = 0;
  logic [PA_W-1:0] last_fa = '0;
  int              mwait = 0;

  // memory model: answers a held request on the third falling edge
  always @(negedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
    end else if (mem_req_valid) begin
      if (mwait == 2) begin
        mwait = 0;
        mem_rsp_data  = mem_img.exists(mem_req_addr) ? mem_img[mem_req_addr] : 32'h0;
        mem_rsp_valid = 1'b1;
        fetch_cnt++;
        last_fa = mem_req_addr;
      end else begin
        mwait++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic xl(input string req, input logic [BA_W-1:0] va, input logic [PA_W-1:0] e_pa,
                    input logic e_f, input logic e_c, input logic e_p, input int e_nf);
    int n = 1;
    int f0 = fetch_cnt;
    @(negedge clk);
    xl_req_valid = 1'b1; xl_req_addr = va;
    @(negedge clk);
    xl_req_valid = 1'b0;
    while (!xl_rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, "paddr", 64'(xl_rsp_paddr), 64'(e_pa));
    chk(req, "fault", 64'(xl_rsp_fault), 64'(e_f));
    chk(req, "cached", 64'(xl_rsp_cached), 64'(e_c));
    chk(req, "prio", 64'(xl_rsp_prio), 64'(e_p));
    chk(req, "fetches", 64'(fetch_cnt - f0), 64'(e_nf));
    if (e_nf == 0) chk(req, "latency", 64'(n), 64'd2);
  endtask

  task automatic program_base(input logic [31:0] dsc0);
    wr(14'h0100, 32'h0000_0100);
    wr(14'h014C, 32'h0000_0001);
    wr(14'h2B00, dsc0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "ready", 64'(xl_req_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(xl_rsp_valid), 64'd0);
    chk("R1", "mem_req", 64'(mem_req_valid), 64'd0);
    rd(14'h0100, d); chk("R1", "cmd", 64'(d), 64'd0);
    rd(14'h014C, d); chk("R1", "win", 64'(d), 64'd0);
    rd(14'h2BFC, d); chk("R1", "dsc63", 64'(d), 64'd0);
  endtask

  task automatic t_pass();
    xl("R2", 40'h12_3456_789A, 42'h12_3456_789A, 0, 0, 0, 0);
    xl("R2", 40'h00_0000_0FFF, 42'h00_0000_0FFF, 0, 0, 0, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(14'h2B14, 32'h1234_5678); rd(14'h2B14, d); chk("R11", "dsc5", 64'(d), 64'h1234_5678);
    wr(14'h014C, 32'hA5A5_0001); rd(14'h014C, d); chk("R11", "win", 64'(d), 64'hA5A5_0001);
    wr(14'h0100, 32'h0000_0100); rd(14'h0100, d); chk("R11", "cmd", 64'(d), 64'h100);
    wr(14'h2D00, 32'h0000_0777); rd(14'h2D00, d); chk("R11", "inv_reads_zero", 64'(d), 64'd0);
  endtask

  task automatic t_big();
    logic [BA_W-1:0] va;
    wr(14'h2B1C, 32'hC157_8002);
    va = 40'h00_0FAB_C123;
    xl("R5", va, {17'h0ABC, va[24:0]}, 0, 1, 0, 0);
    wr(14'h2B24, 32'hC000_2001);
    va = 40'h00_1234_5678;
    xl("R5", va, {17'h0001, va[24:0]}, 0, 0, 1, 0);
  endtask

  task automatic t_window();
    logic [BA_W-1:0] va;
    xl("R3", 40'h00_8E00_0000, '0, 1, 0, 0, 0);
    wr(14'h014C, 32'h3);
    va = 40'h10_0E00_0040;
    xl("R3", va, {17'h0ABC, va[24:0]}, 0, 1, 0, 0);
    xl("R3", 40'h20_0000_0000, '0, 1, 0, 0, 0);
    wr(14'h014C, 32'h0);
    xl("R3", 40'h00_1000_0000, '0, 1, 0, 0, 0);
    va = 40'h00_0E00_0010;
    xl("R3", va, {17'h0ABC, va[24:0]}, 0, 1, 0, 0);
    wr(14'h014C, 32'h2);
    xl("R3", va, '0, 1, 0, 0, 0);
    wr(14'h014C, 32'h1);
  endtask

  task automatic t_dsc();
    xl("R4", 40'h00_0600_0000, '0, 1, 0, 0, 0);
    wr(14'h2B0C, 32'h8000_0000);
    xl("R4", 40'h00_0600_1000, '0, 1, 0, 0, 0);
  endtask

  task automatic t_walk();
    wr(14'h2B00, 32'h4000_0100);
    mem_img[42'h10_0014] = 32'hC003_4567;
    mem_img[42'h10_001C] = 32'h8000_0042;
    xl("R7", 40'h5ABC, {30'h0003_4567, 12'hABC}, 0, 1, 0, 1);
    chk("R6", "fetch_addr", 64'(last_fa), 64'h10_0014);
    xl("R7", 40'h6000, '0, 1, 0, 0, 1);
    chk("R6", "fetch_addr", 64'(last_fa), 64'h10_0018);
    xl("R7", 40'h7001, {30'h42, 12'h001}, 0, 0, 0, 1);
  endtask

  task automatic t_tlb();
    xl("R8", 40'h5123, {30'h0003_4567, 12'h123}, 0, 1, 0, 0);
    wr(14'h2B00, 32'h4000_0200);
    xl("R8", 40'h5FFF, {30'h0003_4567, 12'hFFF}, 0, 1, 0, 0);
    xl("R8", 40'h6000, '0, 1, 0, 0, 1);
  endtask

  task automatic t_inv();
    program_base(32'h4000_0200);
    mem_img[42'h20_0010] = 32'h8000_0777;
    mem_img[42'h20_0014] = 32'h8000_0999;
    mem_img[42'h20_0020] = 32'h8000_0888;
    xl("R9", 40'h4000, {30'h777, 12'h0}, 0, 0, 0, 1);
    xl("R9", 40'h5000, {30'h999, 12'h0}, 0, 0, 0, 1);
    xl("R9", 40'h8000, {30'h888, 12'h0}, 0, 0, 0, 1);
    wr(14'h2D00, 32'h1);
    xl("R9", 40'h5010, {30'h999, 12'h010}, 0, 0, 0, 1);
    xl("R9", 40'h4000, {30'h777, 12'h0}, 0, 0, 0, 1);
    xl("R9", 40'h8004, {30'h888, 12'h004}, 0, 0, 0, 0);
  endtask

  task automatic t_rr();
    program_base(32'h4000_0100);
    for (int p = 16; p <= 24; p++) mem_img[42'h10_0000 + 42'(4 * p)] = 32'h8000_0500 + 32'(p);
    for (int p = 16; p <= 24; p++)
      xl("R10", 40'(p) << 12, {30'h500 + 30'(p), 12'h0}, 0, 0, 0, 1);
    xl("R10", 40'(17) << 12, {30'h511, 12'h0}, 0, 0, 0, 0);
    xl("R10", 40'(16) << 12, {30'h510, 12'h0}, 0, 0, 0, 1);
    xl("R10", 40'(24) << 12, {30'h518, 12'h0}, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    xl_req_valid = 1'b0; xl_req_addr = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    do_reset();
    t_reset();
    t_pass();
    t_regs();
    t_big();
    t_window();
    t_dsc();
    t_walk();
    t_tlb();
    do_reset();
    t_inv();
    do_reset();
    t_rr();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule